// File: doc/BRIEF.md
# Mixed-Format Saturating Fixed-Point Adder

This block adds, or subtracts, two signed two's-complement fixed-point numbers whose binary points sit in different places. Operand A has A_INT integer bits and A_FRAC fraction bits. Operand B has B_INT integer bits and B_FRAC fraction bits. Each operand also carries one sign bit. Both operands are moved onto one common grid. That grid has max(A_INT,B_INT) integer bits and max(A_FRAC,B_FRAC) fraction bits, so the result is 1+max(A_INT,B_INT)+max(A_FRAC,B_FRAC) bits wide. Integer bits are filled by copying the sign, and the missing low fraction bits are filled with zeros.

A run-time mode input picks between two behaviours when the result leaves the representable range: the result either wraps modulo 2^W, or it is pinned at the nearest extreme. The overflow flag reports the event in both modes. A parameter chooses whether the output is combinational or taken from one register stage.

Top module: `qfx_add`

## Requirements
- R1: The result width W is 1+max(A_INT,B_INT)+max(A_FRAC,B_FRAC). When no overflow occurs, `sum` equals the exact value of a+b, read with max(A_FRAC,B_FRAC) fraction bits.
- R2: Alignment sign-extends the integer part and zero-fills the low fraction bits. For example, with A in 3.0 and B in 1.2, a=4'b1111 (-1) plus b=0 gives 6'b111100, and a=0 plus b=4'b1000 (-2.0) gives 6'b111000.
- R3: With `sub_en`=1 the block computes a-b on the same adder, using the inverted aligned b and a carry-in of one. This includes b equal to its most negative value.
- R4: `ovf` is 1 exactly when the true result lies outside [-2^(W-1), 2^(W-1)-1] in units of the result LSB.
- R5: With `sat_en`=0, an overflowing result is the true result modulo 2^W.
- R6: With `sat_en`=1, a positive overflow gives 0 followed by all ones (6'b011111 for 3.0 with 1.2), and a negative overflow gives 1 followed by all zeros (6'b100000).
- R7: `ovf` is raised on overflow whether or not the result was clamped.
- R8: With REG_OUT=1, `sum` and `ovf` show the result for the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset for the output register |
| a | input | 1+A_INT+A_FRAC | Operand A, signed, A_INT.A_FRAC |
| b | input | 1+B_INT+B_FRAC | Operand B, signed, B_INT.B_FRAC |
| sub_en | input | 1 | 1 selects a-b, 0 selects a+b |
| sat_en | input | 1 | 1 clamps on overflow, 0 wraps |
| sum | output | 1+max(A_INT,B_INT)+max(A_FRAC,B_FRAC) | Result in the common format |
| ovf | output | 1 | Result left the representable range |

## Verification
The bench sweeps every pair of 4-bit operands in the 3.0 and 1.2 formats, in both add and subtract mode and in both overflow modes. It compares each result against an integer model scaled by four. A design that aligned the fraction on the wrong side, or padded integer bits with zeros, would give wrong values for negative operands. A design that clamped toward the wrong rail, or tested the sign of the result instead of the operands, would put an out-of-range result on the opposite extreme. Subtracting the most negative b, and overflow with clamping turned off, are aimed at directly. A flag computed only after clamping would stay silent in one of these cases, and a missing carry-in would leave the difference one LSB low. The registered variant is checked during reset and for its one-edge latency.

// File: rtl/qfx_add.sv
`timescale 1ns/1ps
module qfx_add #(
  parameter int A_INT   = 3,
  parameter int A_FRAC  = 0,
  parameter int B_INT   = 1,
  parameter int B_FRAC  = 2,
  parameter bit REG_OUT = 1'b0,
  localparam int AW = 1 + A_INT + A_FRAC,
  localparam int BW = 1 + B_INT + B_FRAC,
  localparam int R_INT  = (A_INT > B_INT) ? A_INT : B_INT,
  localparam int R_FRAC = (A_FRAC > B_FRAC) ? A_FRAC : B_FRAC,
  localparam int RW = 1 + R_INT + R_FRAC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic          sub_en,
  input  logic          sat_en,
  output logic [RW-1:0] sum,
  output logic          ovf
);

  localparam logic [RW-1:0] POS_RAIL = {1'b0, {(RW-1){1'b1}}};
  localparam logic [RW-1:0] NEG_RAIL = {1'b1, {(RW-1){1'b0}}};

  logic [RW-1:0] a_al, b_al, b_op, raw, res;
  logic          wrap_hit;

  assign a_al = RW'($signed(a)) << (R_FRAC - A_FRAC);
  assign b_al = RW'($signed(b)) << (R_FRAC - B_FRAC);
  assign b_op = sub_en ? ~b_al : b_al;
  assign raw  = a_al + b_op + {{(RW-1){1'b0}}, sub_en};

  assign wrap_hit = (a_al[RW-1] == b_op[RW-1]) && (raw[RW-1] != a_al[RW-1]);
  assign res = (sat_en && wrap_hit) ? (a_al[RW-1] ? NEG_RAIL : POS_RAIL) : raw;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum <= '0;
          ovf <= 1'b0;
        end else begin
          sum <= res;
          ovf <= wrap_hit;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign sum = res;
      assign ovf = wrap_hit;
    end
  endgenerate

endmodule

module qfx_add_chk #(
  parameter int A_INT   = 3,
  parameter int A_FRAC  = 0,
  parameter int B_INT   = 1,
  parameter int B_FRAC  = 2,
  parameter bit REG_OUT = 1'b0,
  localparam int AW = 1 + A_INT + A_FRAC,
  localparam int BW = 1 + B_INT + B_FRAC,
  localparam int R_INT  = (A_INT > B_INT) ? A_INT : B_INT,
  localparam int R_FRAC = (A_FRAC > B_FRAC) ? A_FRAC : B_FRAC,
  localparam int RW = 1 + R_INT + R_FRAC,
  localparam int XW = RW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] a,
  input logic [BW-1:0] b,
  input logic          sub_en,
  input logic          sat_en,
  input logic [RW-1:0] sum,
  input logic          ovf
);

  localparam logic [RW-1:0] POS_RAIL = {1'b0, {(RW-1){1'b1}}};
  localparam logic [RW-1:0] NEG_RAIL = {1'b1, {(RW-1){1'b0}}};

  logic [XW-1:0] ax, bx, tr;
  logic          over_now;

  assign ax = XW'($signed(a)) << (R_FRAC - A_FRAC);
  assign bx = XW'($signed(b)) << (R_FRAC - B_FRAC);
  assign tr = sub_en ? (ax - bx) : (ax + bx);
  assign over_now = tr[XW-1] != tr[XW-2];

  logic          e_en, e_over, e_sat;
  logic [RW-1:0] e_raw;

  generate
    if (REG_OUT) begin : g_q
      logic          primed;
      logic          over_q, sat_q;
      logic [RW-1:0] raw_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          primed <= 1'b0;
          over_q <= 1'b0;
          sat_q  <= 1'b0;
          raw_q  <= '0;
        end else begin
          primed <= 1'b1;
          over_q <= over_now;
          sat_q  <= sat_en;
          raw_q  <= tr[RW-1:0];
        end
      end
      assign e_en   = primed;
      assign e_over = over_q;
      assign e_sat  = sat_q;
      assign e_raw  = raw_q;
    end else begin : g_d
      assign e_en   = 1'b1;
      assign e_over = over_now;
      assign e_sat  = sat_en;
      assign e_raw  = tr[RW-1:0];
    end
  endgenerate

  // R1
  exact_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_en && !e_over) |-> (sum == e_raw));

  // R4
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    e_en |-> (ovf == e_over));

  // R5
  wrap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_en && !e_sat) |-> (sum == e_raw));

  // R6
  clamp_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_en && e_sat && e_over) |-> (sum == POS_RAIL || sum == NEG_RAIL));

  // R7
  flag_with_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_en && e_sat && e_over) |-> ovf);

endmodule

bind qfx_add qfx_add_chk #(
  .A_INT(A_INT), .A_FRAC(A_FRAC), .B_INT(B_INT), .B_FRAC(B_FRAC), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sub_en(sub_en), .sat_en(sat_en),
  .sum(sum), .ovf(ovf)
);

// File: tb/qfx_add_test.sv
`timescale 1ns/1ps
module qfx_add_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] a = '0, b = '0;
  logic       sub_en = 1'b0, sat_en = 1'b0;
  logic [5:0] sum, sum_r;
  logic       ovf, ovf_r;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  qfx_add #(.A_INT(3), .A_FRAC(0), .B_INT(1), .B_FRAC(2), .REG_OUT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sub_en(sub_en), .sat_en(sat_en),
    .sum(sum), .ovf(ovf));

  qfx_add #(.A_INT(3), .A_FRAC(0), .B_INT(1), .B_FRAC(2), .REG_OUT(1'b1)) uut_reg (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .sub_en(sub_en), .sat_en(sat_en),
    .sum(sum_r), .ovf(ovf_r));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] ia, input logic [3:0] ib,
                                input logic s, input logic st,
                                output logic [5:0] es, output logic eo);
    int av, bv, t;
    av = $signed(ia) * 4;
    bv = $signed(ib);
    t  = s ? av - bv : av + bv;
    eo = (t > 31) || (t < -32);
    if (eo && st) es = (t > 0) ? 6'b011111 : 6'b100000;
    else          es = 6'(t);
  endfunction

  task automatic drive(input logic [3:0] ia, input logic [3:0] ib,
                       input logic s, input logic st);
    @(negedge clk);
    a = ia; b = ib; sub_en = s; sat_en = st;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    drive(4'd7, 4'd7, 1'b0, 1'b1);
    @(negedge clk);
    check("R8 reset sum", int'(sum_r), 0);
    check("R8 reset ovf", int'(ovf_r), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_align;
    drive(4'b1111, 4'b0000, 1'b0, 1'b0);
    check("R2 sign-extend a", int'(sum), 6'b111100);
    drive(4'b0000, 4'b1000, 1'b0, 1'b0);
    check("R2 sign-extend b", int'(sum), 6'b111000);
    drive(4'b0001, 4'b0001, 1'b0, 1'b0);
    check("R2 zero-fill a", int'(sum), 6'b000101);
  endtask

  task automatic t_sub_edge;
    drive(4'b0000, 4'b1000, 1'b1, 1'b0);
    check("R3 minus most negative b", int'(sum), 6'b001000);
    check("R3 no ovf", int'(ovf), 0);
    drive(4'b0111, 4'b1000, 1'b1, 1'b1);
    check("R6 sub positive clamp", int'(sum), 6'b011111);
    check("R7 ovf on clamp", int'(ovf), 1);
  endtask

  task automatic t_rails;
    drive(4'b0111, 4'b0111, 1'b0, 1'b1);
    check("R6 positive rail", int'(sum), 6'b011111);
    check("R7 ovf clamp pos", int'(ovf), 1);
    drive(4'b1000, 4'b1000, 1'b0, 1'b1);
    check("R6 negative rail", int'(sum), 6'b100000);
    drive(4'b0111, 4'b0111, 1'b0, 1'b0);
    check("R5 wrap pos", int'(sum), 6'b100011);
    check("R4 ovf wrap", int'(ovf), 1);
    drive(4'b1000, 4'b1000, 1'b0, 1'b0);
    check("R5 wrap neg", int'(sum), 6'b011000);
  endtask

  task automatic t_latency;
    logic [5:0] es;
    logic       eo;
    drive(4'b0011, 4'b0110, 1'b0, 1'b0);
    check("R8 holds before edge", int'(sum_r), 6'b011000);
    model(4'b0011, 4'b0110, 1'b0, 1'b0, es, eo);
    @(negedge clk);
    check("R8 one edge later", int'(sum_r), int'(es));
  endtask

  task automatic t_sweep;
    logic [5:0] es;
    logic       eo;
    for (int s = 0; s < 2; s++)
      for (int st = 0; st < 2; st++)
        for (int ia = 0; ia < 16; ia++)
          for (int ib = 0; ib < 16; ib++) begin
            model(4'(ia), 4'(ib), s[0], st[0], es, eo);
            drive(4'(ia), 4'(ib), s[0], st[0]);
            if (eo)
              check(st[0] ? "R6 sweep clamp" : "R5 sweep wrap", int'(sum), int'(es));
            else
              check(s[0] ? "R3 sweep sub" : "R1 sweep add", int'(sum), int'(es));
            check(st[0] ? "R7 sweep flag" : "R4 sweep flag", int'(ovf), int'(eo));
            @(negedge clk);
            check("R8 sweep reg sum", int'(sum_r), int'(es));
            check("R8 sweep reg ovf", int'(ovf_r), int'(eo));
          end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_align();
    t_sub_edge();
    t_rails();
    t_latency();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule